// File: doc/BRIEF.md
# Dual-Port RAM with Selectable Word Shape

This block is a synchronous random-access memory with two fully independent read/write ports, each driven by its own clock and its own synchronous reset. The logical capacity is a fixed 4096-bit array. One parameter picks how that capacity is viewed: as few wide words or many narrow ones. The two wide shapes carry a ninth bit per byte for parity-style storage.

Each port samples its address, write data, write enable and lane enables on its own rising clock edge. A second parameter places an extra register on the read path. The read latency is then one or two clocks. On the 16- and 18-bit shapes, two lane enables choose which half of the word a write touches. A read of an address that the same edge writes returns the contents from before that write. Internally each port owns one storage bank. The stored word is the XOR of the two banks, so each bank has exactly one writer clock.

Top module: `dpr_ram`

## Requirements
- R1: Parameter `W` must be one of 1, 2, 4, 8, 9, 16, 18. The depth is 4096/W words for the power-of-two widths, 512 for W=9 and 256 for W=18, and the address width is log2 of the depth. Any other width, including 32 and 36, stops elaboration with an error.
- R2: A write presented with `we`=1 at a rising edge of a port's clock is stored at that edge. Any read sampled at a later edge returns the stored word.
- R3: The read address is sampled at edge k. With `OUT_REG`=0 the word is on `dout` after edge k. With `OUT_REG`=1 it is on `dout` after edge k+1.
- R4: When a port writes an address at the same edge that samples it for reading, `dout` carries the word held before that write.
- R5: For W of 16 or 18 there are two lanes. `be[0]` enables bits [W/2-1:0] and `be[1]` enables bits [W-1:W/2], so for W=18 each lane is 9 bits wide. For narrower W, the single bit `be[0]` enables the whole word. Bits in disabled lanes keep their old contents.
- R6: A word written through one port is returned by reads on the other port sampled at any later edge of that port's clock.
- R7: Each port acts only on its own clock edges. The two ports may write different addresses at the same time. While one port's clock is stopped, its inputs are ignored and its `dout` holds.
- R8: A port's synchronous reset clears that port's read pipeline, so `dout` is zero after the reset edge. Memory contents are kept.
- R9: When the edges of both clocks coincide and one port writes an address the other port reads, the reading port returns the word held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Clock of port A |
| rst_a | input | 1 | Synchronous active-high reset of port A read pipeline |
| we_a | input | 1 | Port A write enable |
| addr_a | input | AW | Port A word address |
| din_a | input | W | Port A write data |
| be_a | input | NL | Port A lane enables |
| dout_a | output | W | Port A read data |
| clk_b | input | 1 | Clock of port B |
| rst_b | input | 1 | Synchronous active-high reset of port B read pipeline |
| we_b | input | 1 | Port B write enable |
| addr_b | input | AW | Port B word address |
| din_b | input | W | Port B write data |
| be_b | input | NL | Port B lane enables |
| dout_b | output | W | Port B read data |

## Verification
Two events can fall on the same clock edge. One is a write into an address. The other is a read of that same address, either by the writing port itself or by the opposite port when both clocks rise together. The bench provokes both cases. Port A writes a location while, at the same edge, either A or B samples that location, and A also writes one address on two consecutive edges. The bench expects the pre-write word at the output after the configured latency, and the new word from the following read.

// File: rtl/dpr_pkg.sv
package dpr_pkg;
  localparam int unsigned ARRAY_BITS = 4096;

  function automatic bit shape_ok(input int unsigned w);
    return (w == 1) || (w == 2) || (w == 4) || (w == 8) ||
           (w == 9) || (w == 16) || (w == 18);
  endfunction

  function automatic int unsigned depth_of(input int unsigned w);
    if (w == 9)  return 512;
    if (w == 18) return 256;
    if (w == 0)  return 2;
    return ARRAY_BITS / w;
  endfunction

  function automatic int unsigned lanes_of(input int unsigned w);
    return (w >= 16) ? 2 : 1;
  endfunction
endpackage

// File: rtl/dpr_lane_merge.sv
module dpr_lane_merge #(
  parameter int unsigned W  = 18,
  parameter int unsigned NL = 2
) (
  input  logic [W-1:0]  own_word,
  input  logic [W-1:0]  new_word,
  input  logic [W-1:0]  far_word,
  input  logic [NL-1:0] lane_en,
  output logic [W-1:0]  merged
);
  localparam int unsigned LW = W / NL;

  // Each enabled lane stores new ^ far so that own ^ far reads back new.
  for (genvar g = 0; g < NL; g++) begin : g_lane
    assign merged[g*LW +: LW] = lane_en[g] ?
                                (new_word[g*LW +: LW] ^ far_word[g*LW +: LW]) :
                                own_word[g*LW +: LW];
  end
endmodule

// File: rtl/dpr_port.sv
module dpr_port #(
  parameter int unsigned W       = 18,
  parameter int unsigned NL      = 2,
  parameter int unsigned DEPTH   = 256,
  parameter int unsigned AW      = 8,
  parameter bit          OUT_REG = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  din,
  input  logic [NL-1:0] be,
  output logic [W-1:0]  dout,
  // opposite bank word at this port's address
  input  logic [W-1:0]  far_word,
  // this bank, read by the opposite port
  input  logic [AW-1:0] peek_addr,
  output logic [W-1:0]  peek_word
);
  logic [W-1:0] bank [DEPTH];
  logic [W-1:0] own_word;
  logic [W-1:0] wr_word;
  logic [W-1:0] rd_q;

  assign own_word  = bank[addr];
  assign peek_word = bank[peek_addr];

  dpr_lane_merge #(.W(W), .NL(NL)) u_merge (
    .own_word (own_word),
    .new_word (din),
    .far_word (far_word),
    .lane_en  (be),
    .merged   (wr_word)
  );

  always_ff @(posedge clk) begin
    if (we) bank[addr] <= wr_word;
  end

  // Old contents are captured at the write edge: read-before-write.
  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else     rd_q <= own_word ^ far_word;
  end

  if (OUT_REG) begin : g_out_reg
    logic [W-1:0] out_q;
    always_ff @(posedge clk) begin
      if (rst) out_q <= '0;
      else     out_q <= rd_q;
    end
    assign dout = out_q;
  end else begin : g_out_direct
    assign dout = rd_q;
  end
endmodule

// File: rtl/dpr_ram.sv
module dpr_ram
  import dpr_pkg::*;
#(
  parameter int unsigned W       = 18,
  parameter bit          OUT_REG = 1'b1,
  localparam int unsigned DEPTH  = depth_of(W),
  localparam int unsigned AW     = $clog2(DEPTH),
  localparam int unsigned NL     = lanes_of(W)
) (
  input  logic          clk_a,
  input  logic          rst_a,
  input  logic          we_a,
  input  logic [AW-1:0] addr_a,
  input  logic [W-1:0]  din_a,
  input  logic [NL-1:0] be_a,
  output logic [W-1:0]  dout_a,
  input  logic          clk_b,
  input  logic          rst_b,
  input  logic          we_b,
  input  logic [AW-1:0] addr_b,
  input  logic [W-1:0]  din_b,
  input  logic [NL-1:0] be_b,
  output logic [W-1:0]  dout_b
);
  if (!shape_ok(W)) begin : g_bad_shape
    $error("dpr_ram: word width %0d is not a supported shape", W);
  end

  logic [W-1:0] a_bank_at_b;
  logic [W-1:0] b_bank_at_a;

  dpr_port #(.W(W), .NL(NL), .DEPTH(DEPTH), .AW(AW), .OUT_REG(OUT_REG)) u_port_a (
    .clk       (clk_a),
    .rst       (rst_a),
    .we        (we_a),
    .addr      (addr_a),
    .din       (din_a),
    .be        (be_a),
    .dout      (dout_a),
    .far_word  (b_bank_at_a),
    .peek_addr (addr_b),
    .peek_word (a_bank_at_b)
  );

  dpr_port #(.W(W), .NL(NL), .DEPTH(DEPTH), .AW(AW), .OUT_REG(OUT_REG)) u_port_b (
    .clk       (clk_b),
    .rst       (rst_b),
    .we        (we_b),
    .addr      (addr_b),
    .din       (din_b),
    .be        (be_b),
    .dout      (dout_b),
    .far_word  (a_bank_at_b),
    .peek_addr (addr_a),
    .peek_word (b_bank_at_a)
  );
endmodule

// File: rtl/dpr_ram_chk.sv
module dpr_ram_chk
  import dpr_pkg::*;
#(
  parameter int unsigned W       = 18,
  parameter bit          OUT_REG = 1'b1,
  localparam int unsigned DEPTH  = depth_of(W),
  localparam int unsigned AW     = $clog2(DEPTH),
  localparam int unsigned NL     = lanes_of(W)
) (
  input logic          clk_a,
  input logic          rst_a,
  input logic          we_a,
  input logic [AW-1:0] addr_a,
  input logic [W-1:0]  din_a,
  input logic [NL-1:0] be_a,
  input logic [W-1:0]  dout_a,
  input logic          clk_b,
  input logic          rst_b,
  input logic          we_b,
  input logic [AW-1:0] addr_b,
  input logic [W-1:0]  din_b,
  input logic [NL-1:0] be_b,
  input logic [W-1:0]  dout_b
);
  // Track a full-word write and a read of that address on the next edge.
  logic          lw_v_a, h1_a, h2_a;
  logic [AW-1:0] lw_ad_a;
  logic [W-1:0]  lw_d_a, e1_a, e2_a;
  logic          lw_v_b, h1_b, h2_b;
  logic [AW-1:0] lw_ad_b;
  logic [W-1:0]  lw_d_b, e1_b, e2_b;
  logic          hit_a, hit_b;
  logic [W-1:0]  exp_a, exp_b;

  always_ff @(posedge clk_a) begin
    if (rst_a) begin
      lw_v_a <= 1'b0; h1_a <= 1'b0; h2_a <= 1'b0;
    end else begin
      lw_v_a <= we_a && (&be_a);
      h1_a   <= lw_v_a && (addr_a == lw_ad_a);
      h2_a   <= h1_a;
    end
    lw_ad_a <= addr_a; lw_d_a <= din_a; e1_a <= lw_d_a; e2_a <= e1_a;
  end

  always_ff @(posedge clk_b) begin
    if (rst_b) begin
      lw_v_b <= 1'b0; h1_b <= 1'b0; h2_b <= 1'b0;
    end else begin
      lw_v_b <= we_b && (&be_b);
      h1_b   <= lw_v_b && (addr_b == lw_ad_b);
      h2_b   <= h1_b;
    end
    lw_ad_b <= addr_b; lw_d_b <= din_b; e1_b <= lw_d_b; e2_b <= e1_b;
  end

  assign hit_a = OUT_REG ? h2_a : h1_a;
  assign exp_a = OUT_REG ? e2_a : e1_a;
  assign hit_b = OUT_REG ? h2_b : h1_b;
  assign exp_b = OUT_REG ? e2_b : e1_b;

  // R8
  rst_a_clear_chk: assert property (@(posedge clk_a) rst_a |=> (dout_a == '0));
  // R8
  rst_b_clear_chk: assert property (@(posedge clk_b) rst_b |=> (dout_b == '0));
  // R4
  rbw_a_chk: assert property (@(posedge clk_a) disable iff (rst_a) hit_a |-> (dout_a == exp_a));
  // R4
  rbw_b_chk: assert property (@(posedge clk_b) disable iff (rst_b) hit_b |-> (dout_b == exp_b));
endmodule

bind dpr_ram dpr_ram_chk #(.W(W), .OUT_REG(OUT_REG)) u_chk (
  .clk_a (clk_a), .rst_a (rst_a), .we_a (we_a), .addr_a (addr_a),
  .din_a (din_a), .be_a (be_a), .dout_a (dout_a),
  .clk_b (clk_b), .rst_b (rst_b), .we_b (we_b), .addr_b (addr_b),
  .din_b (din_b), .be_b (be_b), .dout_b (dout_b)
);

// File: tb/dpr_ram_bench.sv
`timescale 1ns/1ps
module dpr_ram_bench;
  localparam int N  = 256;
  localparam int NN = 1024;

  logic clk_a = 1'b0, clk_b = 1'b0, run_b = 1'b1;
  logic rst_a = 1'b1, rst_b = 1'b1;
  logic we_a = 1'b0, we_b = 1'b0;
  logic [7:0]  addr_a = '0, addr_b = '0;
  logic [17:0] din_a = '0, din_b = '0;
  logic [1:0]  be_a = '0, be_b = '0;
  logic [17:0] dout_a, dout_b;
  logic n_we_a = 1'b0, n_we_b = 1'b0;
  logic [9:0] n_addr_a = '0, n_addr_b = '0;
  logic [3:0] n_din_a = '0, n_din_b = '0;
  logic [0:0] n_be_a = '0, n_be_b = '0;
  logic [3:0] n_dout_a, n_dout_b;

  int nchk = 0, nerr = 0;
  logic [17:0] mw [N];
  logic [3:0]  nm [NN];
  logic [17:0] oldv [16];
  logic [17:0] held, prev5, d1, d2;

  always #2.5 clk_a = ~clk_a;
  always #2.5 if (run_b) clk_b = ~clk_b;

  dpr_ram #(.W(18), .OUT_REG(1'b1)) u_dpr_ram (
    .clk_a(clk_a), .rst_a(rst_a), .we_a(we_a), .addr_a(addr_a), .din_a(din_a),
    .be_a(be_a), .dout_a(dout_a),
    .clk_b(clk_b), .rst_b(rst_b), .we_b(we_b), .addr_b(addr_b), .din_b(din_b),
    .be_b(be_b), .dout_b(dout_b)
  );

  dpr_ram #(.W(4), .OUT_REG(1'b0)) u_dpr_ram_narrow (
    .clk_a(clk_a), .rst_a(rst_a), .we_a(n_we_a), .addr_a(n_addr_a), .din_a(n_din_a),
    .be_a(n_be_a), .dout_a(n_dout_a),
    .clk_b(clk_b), .rst_b(rst_b), .we_b(n_we_b), .addr_b(n_addr_b), .din_b(n_din_b),
    .be_b(n_be_b), .dout_b(n_dout_b)
  );

  function automatic logic [17:0] pat(input int a, input int s);
    return 18'((a * 613) ^ (s * 40503) ^ (a << 10) ^ 5);
  endfunction

  task automatic chk(input string req, input logic [17:0] act, input logic [17:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Latency-2 read sweeps over the whole wide array.
  task automatic sweep_a(input string req);
    for (int i = 0; i < N + 2; i++) begin
      @(negedge clk_a);
      if (i >= 2) chk(req, dout_a, mw[i-2]);
      we_a = 1'b0;
      if (i < N) addr_a = 8'(i);
    end
  endtask

  task automatic sweep_b(input string req);
    for (int i = 0; i < N + 2; i++) begin
      @(negedge clk_a);
      if (i >= 2) chk(req, dout_b, mw[i-2]);
      we_b = 1'b0;
      if (i < N) addr_b = 8'(i);
    end
  endtask

  task automatic sweep_n(input string req);
    for (int i = 0; i < NN + 1; i++) begin
      @(negedge clk_a);
      if (i >= 1) chk(req, 18'(n_dout_b), 18'(nm[i-1]));
      if (i < NN) n_addr_b = 10'(i);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk_a);
    chk("R8 reset dout_a", dout_a, '0);
    chk("R8 reset dout_b", dout_b, '0);
    chk("R8 reset narrow dout_b", 18'(n_dout_b), '0);
    rst_a = 1'b0; rst_b = 1'b0;

    // R2 R6 R3: fill through A, read back through B (latency 2)
    for (int i = 0; i < N; i++) begin
      @(negedge clk_a);
      we_a = 1'b1; addr_a = 8'(i); din_a = pat(i, 1); be_a = 2'b11;
      mw[i] = pat(i, 1);
    end
    sweep_b("R2/R6 B reads A writes");

    // R5: every lane-enable pattern over the array, 9-bit lanes
    for (int i = 0; i < N; i++) begin
      @(negedge clk_a);
      we_a = 1'b1; addr_a = 8'(i); din_a = pat(i, 2); be_a = 2'(i);
      if (be_a[0]) mw[i][8:0]  = din_a[8:0];
      if (be_a[1]) mw[i][17:9] = din_a[17:9];
    end
    sweep_a("R5 lane masking");

    // R4: each write returns the old word at latency 2
    for (int i = 0; i < 18; i++) begin
      @(negedge clk_a);
      if (i >= 2) chk("R4 read-before-write", dout_a, oldv[i-2]);
      if (i < 16) begin
        we_a = 1'b1; addr_a = 8'(i); din_a = pat(i, 3); be_a = 2'b11;
        oldv[i] = mw[i]; mw[i] = pat(i, 3);
      end else we_a = 1'b0;
    end
    // R4: two writes to one address on consecutive edges
    d1 = pat(20, 4); d2 = pat(20, 5);
    for (int j = 0; j < 5; j++) begin
      @(negedge clk_a);
      if (j == 0) begin we_a = 1'b1; addr_a = 8'd20; din_a = d1; end
      if (j == 1) din_a = d2;
      if (j == 2) we_a = 1'b0;
      if (j == 3) chk("R4 back-to-back old word", dout_a, d1);
      if (j == 4) chk("R4 back-to-back new word", dout_a, d2);
    end
    mw[20] = d2;

    // R7: both ports write disjoint halves at the same time
    for (int i = 0; i < 128; i++) begin
      @(negedge clk_a);
      we_a = 1'b1; addr_a = 8'(128 + i); din_a = pat(128 + i, 6); be_a = 2'b11;
      we_b = 1'b1; addr_b = 8'(i);       din_b = pat(i, 7);       be_b = 2'b11;
      mw[128 + i] = pat(128 + i, 6); mw[i] = pat(i, 7);
    end
    @(negedge clk_a); we_b = 1'b0;
    sweep_a("R7 concurrent writes");

    // R9: coincident edges, A writes address 5 while B reads it
    prev5 = mw[5];
    for (int j = 0; j < 4; j++) begin
      @(negedge clk_a);
      if (j == 0) begin
        we_a = 1'b1; addr_a = 8'd5; din_a = pat(5, 8); be_a = 2'b11; addr_b = 8'd5;
      end
      if (j == 1) we_a = 1'b0;
      if (j == 2) chk("R9 cross-port old word", dout_b, prev5);
      if (j == 3) chk("R9 cross-port new word", dout_b, pat(5, 8));
    end
    mw[5] = pat(5, 8);

    // R7: stop clk_b; its inputs are ignored and dout_b holds
    @(negedge clk_a); #1 run_b = 1'b0;
    held = dout_b;
    we_b = 1'b1; addr_b = 8'd200; din_b = ~mw[200]; be_b = 2'b11;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk_a);
      we_a = 1'b1; addr_a = 8'(7 + i); din_a = pat(7 + i, 9); be_a = 2'b11;
      mw[7 + i] = pat(7 + i, 9);
      chk("R7 stopped port holds", dout_b, held);
    end
    @(negedge clk_a);
    we_a = 1'b0; we_b = 1'b0; addr_b = '0;
    chk("R7 stopped port holds", dout_b, held);
    #1 run_b = 1'b1;
    sweep_b("R7/R6 after restart");

    // R8: reset mid-run clears output, keeps memory
    @(negedge clk_a); addr_a = 8'd3; we_a = 1'b0;
    @(negedge clk_a);
    @(negedge clk_a); chk("R3 latency before reset", dout_a, mw[3]);
    rst_a = 1'b1;
    @(negedge clk_a); chk("R8 dout_a cleared", dout_a, '0);
    rst_a = 1'b0;
    @(negedge clk_a);
    @(negedge clk_a); chk("R8 contents kept", dout_a, mw[3]);

    // R1 R3: narrow 1024x4 shape, latency 1, full depth
    for (int i = 0; i < NN; i++) begin
      @(negedge clk_a);
      n_we_a = 1'b1; n_addr_a = 10'(i); n_be_a = 1'b1;
      n_din_a = 4'(i ^ (i >> 4) ^ (i >> 8) ^ 3);
      nm[i] = n_din_a;
    end
    @(negedge clk_a); n_we_a = 1'b0;
    sweep_n("R1/R3 narrow depth and latency");

    // R5: narrow shape, lane enable low blocks the write
    for (int i = 0; i < 8; i++) begin
      @(negedge clk_a);
      n_we_a = 1'b1; n_addr_a = 10'(i); n_be_a = 1'b0; n_din_a = ~nm[i];
    end
    @(negedge clk_a); n_we_a = 1'b0;
    sweep_n("R5 disabled lane ignored");

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_a);
    nchk++; nerr++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule